// File: doc/BRIEF.md
# Scheduled I/O Staging Bridge

This block sits between one I/O peripheral and the system memory bus and decouples the two in time. Words the peripheral writes land in a small circular staging RAM inside the bridge instead of main memory. The peripheral sees an ordinary write port with a ready signal, so the redirection is invisible to it. A single-word DMA mover later copies the staged words to consecutive main-memory addresses starting at a programmable base. It starts a copy only while the system co-scheduler leaves this bridge unblocked.

The bridge tells the co-scheduler whether it holds undelivered traffic. The scheduler answers with a block level that confines main-memory traffic to the windows it chooses. If block rises while a word is on the memory port, that word still completes. The mover then pauses, keeps its address offset, and resumes with the next word.

The bridge also acknowledges the peripheral's interrupt request by itself. It records the event as a pending CPU interrupt. That interrupt reaches the CPU only while the compatible-interval input is high, and it stays pending through predictable intervals until the CPU acknowledges it.

Top module: `rtb_bridge`

## Requirements
- R1: With DEPTH words buffered and not yet delivered, `per_wr_ready` is low. A write presented while it is low is discarded: that word is never delivered.
- R2: `sched_data_rdy` is high exactly when at least one accepted word has not yet completed its memory handshake, including a word currently on the memory port.
- R3: The memory port starts a new word (`mem_wr_en` rising) only at a clock edge where `sched_block` was low.
- R4: Once `mem_wr_en` is high, it stays high with unchanged `mem_wr_addr` and `mem_wr_data` until a cycle with `mem_wr_ack` high completes the word. This holds even if `sched_block` rises meanwhile.
- R5: Words reach memory in acceptance order. The n-th delivered word since reset (n from 0) uses address `mem_base + n` modulo 2^AW, and a pause under block skips no address.
- R6: When `per_irq` is sampled high while `per_irq_ack` is low, `per_irq_ack` is high for the following cycle only.
- R7: Each peripheral interrupt acknowledged by the bridge sets a pending flag. `cpu_irq` equals that flag while `compat_ivl` is high and is low while `compat_ivl` is low, with the flag kept.
- R8: A `cpu_ack` cycle clears the pending flag. If a peripheral interrupt is acknowledged in the same cycle, the flag stays set.
- R9: After reset, `per_wr_ready` is 1 and `sched_data_rdy`, `mem_wr_en`, `per_irq_ack` and `cpu_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| per_wr_valid | input | 1 | Peripheral presents a word |
| per_wr_data | input | DW | Peripheral word |
| per_wr_ready | output | 1 | Staging RAM can take a word |
| per_irq | input | 1 | Peripheral interrupt request |
| per_irq_ack | output | 1 | Bridge acknowledge to the peripheral |
| sched_data_rdy | output | 1 | Undelivered traffic present, to co-scheduler |
| sched_block | input | 1 | Co-scheduler forbids starting memory traffic |
| mem_base | input | AW | Main-memory base address for delivered words |
| mem_wr_en | output | 1 | Memory write request |
| mem_wr_addr | output | AW | Memory write address |
| mem_wr_data | output | DW | Memory write data |
| mem_wr_ack | input | 1 | Memory accepts the current word |
| compat_ivl | input | 1 | CPU is in a compatible interval |
| cpu_ack | input | 1 | CPU acknowledges the pending interrupt |
| cpu_irq | output | 1 | Interrupt to the CPU |

## Verification
A fill count that drifts from the true occupancy shows within one cycle as a wrong `per_wr_ready` or `sched_data_rdy`, and later as a lost or repeated word in the delivered stream. A wrong head index or address offset shows on the first handshake after the fault as a data or address mismatch against the in-order expectation. A mover that ignores block shows as a `mem_wr_en` rise after a blocked edge. A pending flag that is not held or not cleared shows on `cpu_irq` in the first cycle that `compat_ivl` is high.

// File: rtl/rtb_pkg.sv
package rtb_pkg;
  // next ring index, wrapping at n
  function automatic int unsigned wrap_inc(int unsigned i, int unsigned n);
    return (i + 1 == n) ? 0 : i + 1;
  endfunction

  // occupancy after one cycle of push/pop activity
  function automatic int unsigned fill_after(int unsigned f, logic push, logic pop);
    return f + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction

  // address of the k-th delivered word
  function automatic int unsigned word_addr(int unsigned base, int unsigned k);
    return base + k;
  endfunction
endpackage

// File: rtl/rtb_ring.sv
module rtb_ring #(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push,
  input  logic [DW-1:0]                 push_data,
  input  logic                          pop,
  output logic [DW-1:0]                 head_data,
  output logic [$clog2(DEPTH+1)-1:0]    fill,
  output logic                          full,
  output logic                          empty
);
  import rtb_pkg::*;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_idx, rd_idx;

  always_ff @(posedge clk) begin
    if (push) mem[wr_idx] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx <= '0;
      rd_idx <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_idx <= PW'(wrap_inc(32'(wr_idx), DEPTH));
      if (pop)  rd_idx <= PW'(wrap_inc(32'(rd_idx), DEPTH));
      fill <= CW'(fill_after(32'(fill), push, pop));
    end
  end

  assign head_data = mem[rd_idx];
  assign full      = (fill == CW'(DEPTH));
  assign empty     = (fill == '0);
endmodule

// File: rtl/rtb_dma.sv
module rtb_dma #(
  parameter int DW = 16,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          avail,
  input  logic          block,
  input  logic [DW-1:0] head_data,
  input  logic [AW-1:0] base,
  output logic          mem_en,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  input  logic          mem_ack,
  output logic          start,
  output logic          pop
);
  import rtb_pkg::*;
  logic          busy;
  logic [AW-1:0] ofs;

  assign start  = !busy && avail && !block;
  assign pop    = busy && mem_ack;
  assign mem_en = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      ofs      <= '0;
      mem_addr <= '0;
      mem_data <= '0;
    end else begin
      if (start) begin
        busy     <= 1'b1;
        mem_addr <= AW'(word_addr(32'(base), 32'(ofs)));
        mem_data <= head_data;
      end else if (pop) begin
        busy <= 1'b0;
        ofs  <= ofs + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtb_irq.sv
module rtb_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic per_irq,
  output logic per_ack,
  input  logic compat,
  input  logic cpu_ack,
  output logic cpu_irq,
  output logic set_evt
);
  logic pending;

  assign set_evt = per_irq && !per_ack;
  assign cpu_irq = pending && compat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_ack <= 1'b0;
      pending <= 1'b0;
    end else begin
      per_ack <= set_evt;
      pending <= set_evt || (pending && !cpu_ack);
    end
  end
endmodule

// File: rtl/rtb_bridge.sv
module rtb_bridge #(
  parameter int DW    = 16,
  parameter int AW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          per_wr_valid,
  input  logic [DW-1:0] per_wr_data,
  output logic          per_wr_ready,
  input  logic          per_irq,
  output logic          per_irq_ack,
  output logic          sched_data_rdy,
  input  logic          sched_block,
  input  logic [AW-1:0] mem_base,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data,
  input  logic          mem_wr_ack,
  input  logic          compat_ivl,
  input  logic          cpu_ack,
  output logic          cpu_irq
);
  localparam int CW = $clog2(DEPTH+1);

  // named internal events for the checker
  logic          push_evt, pop_evt, start_evt, irq_set_evt;
  logic          ring_full, ring_empty;
  logic [CW-1:0] fill;
  logic [DW-1:0] head_data;

  assign per_wr_ready   = !ring_full;
  assign push_evt       = per_wr_valid && per_wr_ready;
  assign sched_data_rdy = !ring_empty;

  rtb_ring #(.DW(DW), .DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .push(push_evt), .push_data(per_wr_data),
    .pop(pop_evt), .head_data(head_data), .fill(fill),
    .full(ring_full), .empty(ring_empty)
  );

  rtb_dma #(.DW(DW), .AW(AW)) u_dma (
    .clk(clk), .rst_n(rst_n), .avail(!ring_empty), .block(sched_block),
    .head_data(head_data), .base(mem_base), .mem_en(mem_wr_en),
    .mem_addr(mem_wr_addr), .mem_data(mem_wr_data), .mem_ack(mem_wr_ack),
    .start(start_evt), .pop(pop_evt)
  );

  rtb_irq u_irq (
    .clk(clk), .rst_n(rst_n), .per_irq(per_irq), .per_ack(per_irq_ack),
    .compat(compat_ivl), .cpu_ack(cpu_ack), .cpu_irq(cpu_irq),
    .set_evt(irq_set_evt)
  );
endmodule

// File: rtl/rtb_bridge_chk.sv
module rtb_bridge_chk #(
  parameter int DW    = 16,
  parameter int AW    = 16,
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       per_wr_ready,
  input logic                       push_evt,
  input logic                       pop_evt,
  input logic [$clog2(DEPTH+1)-1:0] fill,
  input logic                       sched_data_rdy,
  input logic                       sched_block,
  input logic                       mem_wr_en,
  input logic [AW-1:0]              mem_wr_addr,
  input logic [DW-1:0]              mem_wr_data,
  input logic                       mem_wr_ack,
  input logic                       per_irq_ack,
  input logic                       irq_set_evt,
  input logic                       compat_ivl,
  input logic                       cpu_ack,
  input logic                       cpu_irq
);
  localparam int CW = $clog2(DEPTH+1);

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == CW'(DEPTH) && !pop_evt) |=> (fill == CW'(DEPTH) && !per_wr_ready));

  p_pop_needs_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pop_evt |-> sched_data_rdy);

  p_start_unblocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_en) |-> !$past(sched_block));

  p_hold_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && !mem_wr_ack) |=>
      (mem_wr_en && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  p_ack_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    per_irq_ack |=> !per_irq_ack);

  p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> compat_ivl);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && !irq_set_evt) |=> !cpu_irq);
endmodule

bind rtb_bridge rtb_bridge_chk #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .per_wr_ready(per_wr_ready), .push_evt(push_evt),
  .pop_evt(pop_evt), .fill(fill), .sched_data_rdy(sched_data_rdy),
  .sched_block(sched_block), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
  .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack), .per_irq_ack(per_irq_ack),
  .irq_set_evt(irq_set_evt), .compat_ivl(compat_ivl), .cpu_ack(cpu_ack),
  .cpu_irq(cpu_irq)
);

// File: tb/test_rtb_bridge.sv
`timescale 1ns/1ps
module test_rtb_bridge;
  localparam int DW = 16, AW = 16, DEPTH = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic per_wr_valid = 1'b0, per_irq = 1'b0, sched_block = 1'b0;
  logic mem_wr_ack = 1'b0, compat_ivl = 1'b0, cpu_ack = 1'b0;
  logic [DW-1:0] per_wr_data = '0;
  logic [AW-1:0] mem_base = 16'h4000;
  logic per_wr_ready, per_irq_ack, sched_data_rdy, mem_wr_en, cpu_irq;
  logic [AW-1:0] mem_wr_addr;
  logic [DW-1:0] mem_wr_data;

  int vectors = 0, miscompares = 0;
  int acc = 0, del = 0, cyc = 0, ack_mode = 0;
  logic [DW-1:0] exp_q[$];
  logic prev_en = 1'b0, prev_ack = 1'b0, prev_block = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  logic [DW-1:0] prev_data = '0;

  always #4 clk = ~clk;

  rtb_bridge #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) i_rtb_bridge (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // memory acknowledge pattern
  always @(posedge clk) begin
    cyc++;
    #1 mem_wr_ack = (ack_mode == 0) ? 1'b1 : (ack_mode == 1) ? (cyc % 3 == 0) : 1'b0;
  end

  // monitor / scoreboard at mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      int occ;
      occ = acc - del;
      chk(per_wr_ready == (occ < DEPTH), "R1 ready", per_wr_ready, occ < DEPTH);
      chk(sched_data_rdy == (occ > 0), "R2 data_rdy", sched_data_rdy, occ > 0);
      if (mem_wr_en && !prev_en)
        chk(!prev_block, "R3 start while blocked", prev_block, 0);
      if (prev_en && !prev_ack) begin
        chk(mem_wr_en, "R4 en dropped", mem_wr_en, 1);
        chk(mem_wr_addr == prev_addr, "R4 addr moved", mem_wr_addr, prev_addr);
        chk(mem_wr_data == prev_data, "R4 data moved", mem_wr_data, prev_data);
      end
      if (per_wr_valid && per_wr_ready) begin
        exp_q.push_back(per_wr_data);
        acc++;
      end
      if (mem_wr_en && mem_wr_ack) begin
        logic [AW-1:0] ea;
        ea = mem_base + AW'(del);
        if (exp_q.size() == 0) chk(0, "R5 unexpected word", mem_wr_data, 0);
        else begin
          logic [DW-1:0] ed;
          ed = exp_q.pop_front();
          chk(mem_wr_data == ed, "R5 data order", mem_wr_data, ed);
        end
        chk(mem_wr_addr == ea, "R5 address", mem_wr_addr, ea);
        del++;
      end
      prev_en = mem_wr_en; prev_ack = mem_wr_ack; prev_block = sched_block;
      prev_addr = mem_wr_addr; prev_data = mem_wr_data;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic write_burst(input int n, input logic [DW-1:0] seed);
    for (int i = 0; i < n; i++) begin
      step();
      per_wr_valid = 1'b1;
      per_wr_data  = seed + DW'(i * 7);
    end
    step();
    per_wr_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && (acc != del); i++) step();
    chk(acc == del, "R2 drained", acc - del, 0);
  endtask

  initial begin
    #100;
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(per_wr_ready == 1'b1, "R9 ready", per_wr_ready, 1);
    chk(sched_data_rdy == 1'b0, "R9 data_rdy", sched_data_rdy, 0);
    chk(mem_wr_en == 1'b0, "R9 mem_wr_en", mem_wr_en, 0);
    chk(per_irq_ack == 1'b0, "R9 per_irq_ack", per_irq_ack, 0);
    chk(cpu_irq == 1'b0, "R9 cpu_irq", cpu_irq, 0);

    // R5 free-flowing delivery
    ack_mode = 0;
    write_burst(5, 16'h1000);
    drain();

    // R1 fill while blocked; extra words discarded
    step(); sched_block = 1'b1;
    write_burst(DEPTH + 3, 16'h2000);
    for (int i = 0; i < 6; i++) step();
    @(negedge clk);
    chk(per_wr_ready == 1'b0, "R1 full", per_wr_ready, 0);
    chk(mem_wr_en == 1'b0, "R3 blocked idle", mem_wr_en, 0);

    // R4 block raised while a word waits on the port
    ack_mode = 2;
    step(); sched_block = 1'b0;
    for (int i = 0; i < 20 && !mem_wr_en; i++) step();
    sched_block = 1'b1;
    for (int i = 0; i < 4; i++) step();
    ack_mode = 1;
    for (int i = 0; i < 8; i++) step();
    @(negedge clk);
    chk(mem_wr_en == 1'b0, "R4 paused after word", mem_wr_en, 0);
    step(); sched_block = 1'b0;
    drain();

    // interleaved writes and slow memory
    write_burst(12, 16'h3000);
    drain();

    // R6/R7 interrupt handling
    ack_mode = 0;
    step(); compat_ivl = 1'b0; per_irq = 1'b1;
    @(negedge clk);
    chk(per_irq_ack == 1'b0, "R6 ack not early", per_irq_ack, 0);
    step(); per_irq = 1'b0;
    @(negedge clk);
    chk(per_irq_ack == 1'b1, "R6 ack pulse", per_irq_ack, 1);
    chk(cpu_irq == 1'b0, "R7 held in predictable", cpu_irq, 0);
    step();
    @(negedge clk);
    chk(per_irq_ack == 1'b0, "R6 ack one cycle", per_irq_ack, 0);
    step(); compat_ivl = 1'b1;
    @(negedge clk);
    chk(cpu_irq == 1'b1, "R7 raised in compatible", cpu_irq, 1);
    step(); compat_ivl = 1'b0;
    @(negedge clk);
    chk(cpu_irq == 1'b0, "R7 masked again", cpu_irq, 0);

    // R8 new event wins over clear
    step(); compat_ivl = 1'b1; cpu_ack = 1'b1; per_irq = 1'b1;
    step(); cpu_ack = 1'b0; per_irq = 1'b0;
    @(negedge clk);
    chk(cpu_irq == 1'b1, "R8 set wins", cpu_irq, 1);
    step(); step(); cpu_ack = 1'b1;
    step(); cpu_ack = 1'b0;
    @(negedge clk);
    chk(cpu_irq == 1'b0, "R8 cleared", cpu_irq, 0);

    finish_run();
  end

  initial begin
    #(8 * 100000);
    miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule